// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Initiator

This block is a synchronous bus master that moves one 32-bit word per transaction over a shared bus. Address and data use the same lines. A local client presents an address, write data and a direction bit. The block then requests the bus from a central arbiter over an active-low request line. It waits for an active-low grant while the shared bus is idle, and runs an address phase followed by one data phase.

A read drives the address for one cycle and then releases the lines for a turnaround cycle, so the target can drive the word back. A write places the data on the lines straight after the address. The target stretches the data phase by holding its ready line high. When the target accepts or supplies the word, the block spends one idle cycle with the bus released. In that cycle it pulses a done strobe and presents any read data to the client.

Top module: `mux_bus_initiator`

## Requirements
- R1: While reset is held and right after it, reqN=1, frameN=1, adOe=0, doneValid=0 and cmdReady=1.
- R2: A command is taken when cmdValid=1 and cmdReady=1 at a clock edge. In the next cycle reqN=0 and frameN=1, and reqN stays low until the address phase.
- R3: The address phase starts in the cycle after the first edge at which gntN=0 and busFrameN=1. No address phase starts while either condition fails.
- R4: In the address phase frameN=0, adOe=1 and adOut carries the address. cmdType is 4'b0110 for a read and 4'b0111 for a write.
- R5: For a read, the cycle after the address phase is a turnaround with adOe=0 and frameN=0. The data phase that follows keeps adOe=0.
- R6: For a write, the cycle after the address phase is the data phase with adOe=1, adOut equal to the write data, frameN=0 and cmdType=4'b0000 (all byte lanes enabled, active low).
- R7: A data phase in which trdyN=1 at the clock edge repeats with frameN, adOe, adOut and cmdType unchanged.
- R8: The edge at which trdyN=0 during a data phase ends it. The next cycle is an idle cycle with frameN=1, adOe=0 and doneValid=1 for that one cycle only. For a read, doneRdata equals adIn sampled at that edge.
- R9: reqN is high from the address phase until the next command is taken.
- R10: cmdReady is low from acceptance through the idle cycle. A cmdValid seen while cmdReady=0 starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Client presents a command |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | 32 | Transaction address |
| cmdWdata | input | 32 | Write data |
| cmdReady | output | 1 | Block is idle and takes a command |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 32 | Read data, valid with doneValid on reads |
| reqN | output | 1 | Active-low bus request to the arbiter |
| gntN | input | 1 | Active-low bus grant from the arbiter |
| busFrameN | input | 1 | Shared frame line seen on the bus, high when the bus is idle |
| frameN | output | 1 | Active-low frame strobe driven by this master |
| cmdType | output | 4 | Command in the address phase, byte enables in the data phase |
| adOut | output | 32 | Address/data value to drive |
| adOe | output | 1 | Output enable for adOut |
| adIn | input | 32 | Address/data value on the bus |
| trdyN | input | 1 | Active-low target ready |

## Verification
The assertions assume that the arbiter grants only while a request is pending. They also assume that the target asserts trdyN only inside a data phase, and that for a read it drives adIn in that same cycle. The bench acts as arbiter and target. It lowers gntN only after reqN has fallen, optionally holds busFrameN low to mimic another master, and drives trdyN and adIn only in cycles it has computed to be data phases.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_RD = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_WR = 4'b0111;
  localparam logic [CMD_W-1:0] BE_ALL = 4'b0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ADDR, ST_TURN, ST_DATA, ST_GAP
  } mbi_state_e;

  typedef struct packed {
    logic capture;
    logic latchRd;
    logic driveAddr;
    logic oe;
    logic frame;
    logic req;
    logic done;
  } mbi_strb_t;
endpackage

// File: rtl/mbi_ctrl.sv
module mbi_ctrl
  import mbi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      isWrite,
  input  logic      gntN,
  input  logic      busFrameN,
  input  logic      trdyN,
  output logic      cmdReady,
  output mbi_strb_t strb
);
  mbi_state_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE: if (cmdValid)           stNext = ST_REQ;
      ST_REQ:  if (!gntN && busFrameN) stNext = ST_ADDR;
      ST_ADDR: stNext = isWrite ? ST_DATA : ST_TURN;
      ST_TURN: stNext = ST_DATA;
      ST_DATA: if (!trdyN)             stNext = ST_GAP;
      ST_GAP:  stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_comb begin
    cmdReady       = (st == ST_IDLE);
    strb           = '0;
    strb.capture   = (st == ST_IDLE) && cmdValid;
    strb.latchRd   = (st == ST_DATA) && !trdyN && !isWrite;
    strb.driveAddr = (st == ST_ADDR);
    strb.oe        = (st == ST_ADDR) || ((st == ST_DATA) && isWrite);
    strb.frame     = (st == ST_ADDR) || (st == ST_TURN) || (st == ST_DATA);
    strb.req       = (st == ST_REQ);
    strb.done      = (st == ST_GAP);
  end
endmodule

// File: rtl/mbi_dpath.sv
module mbi_dpath
  import mbi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbi_strb_t        strb,
  input  logic             cmdWrite,
  input  logic [DW-1:0]    cmdAddr,
  input  logic [DW-1:0]    cmdWdata,
  input  logic [DW-1:0]    adIn,
  output logic             isWrite,
  output logic [DW-1:0]    adOut,
  output logic [CMD_W-1:0] cmdType,
  output logic [DW-1:0]    doneRdata
);
  logic [DW-1:0] addrQ, wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      isWrite   <= 1'b0;
      doneRdata <= '0;
    end else begin
      if (strb.capture) begin
        addrQ   <= cmdAddr;
        wdataQ  <= cmdWdata;
        isWrite <= cmdWrite;
      end
      if (strb.latchRd) doneRdata <= adIn;
    end
  end

  always_comb begin
    adOut   = strb.driveAddr ? addrQ : wdataQ;
    cmdType = strb.driveAddr ? (isWrite ? CMD_WR : CMD_RD) : BE_ALL;
  end
endmodule

// File: rtl/mux_bus_initiator.sv
module mux_bus_initiator
  import mbi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [DW-1:0]    cmdAddr,
  input  logic [DW-1:0]    cmdWdata,
  output logic             cmdReady,
  output logic             doneValid,
  output logic [DW-1:0]    doneRdata,
  output logic             reqN,
  input  logic             gntN,
  input  logic             busFrameN,
  output logic             frameN,
  output logic [CMD_W-1:0] cmdType,
  output logic [DW-1:0]    adOut,
  output logic             adOe,
  input  logic [DW-1:0]    adIn,
  input  logic             trdyN
);
  mbi_strb_t strb;
  logic      isWrite;

  mbi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .isWrite(isWrite),
    .gntN(gntN), .busFrameN(busFrameN), .trdyN(trdyN),
    .cmdReady(cmdReady), .strb(strb)
  );

  mbi_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .adIn(adIn),
    .isWrite(isWrite), .adOut(adOut), .cmdType(cmdType),
    .doneRdata(doneRdata)
  );

  assign reqN      = !strb.req;
  assign frameN    = !strb.frame;
  assign adOe      = strb.oe;
  assign doneValid = strb.done;
endmodule

// File: rtl/mux_bus_initiator_chk.sv
module mux_bus_initiator_chk
  import mbi_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqN,
  input logic             gntN,
  input logic             busFrameN,
  input logic             frameN,
  input logic [CMD_W-1:0] cmdType,
  input logic [DW-1:0]    adOut,
  input logic             adOe,
  input logic             trdyN,
  input logic             doneValid
);
  AST_FRAME_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> $past(!gntN && busFrameN && !reqN)); // R3
  AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && cmdType == CMD_RD) |=> (!adOe && !frameN)); // R5
  AST_WRITE_NO_TURN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && cmdType == CMD_WR) |=> (adOe && !frameN && cmdType == BE_ALL)); // R6
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!frameN && $past(!frameN) && trdyN) |=> (!frameN && $stable(adOut) && $stable(adOe))); // R7
  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameN) |-> (doneValid && !adOe)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R8
  AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> reqN); // R9
endmodule

bind mux_bus_initiator mux_bus_initiator_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .reqN(reqN), .gntN(gntN), .busFrameN(busFrameN),
  .frameN(frameN), .cmdType(cmdType), .adOut(adOut), .adOe(adOe),
  .trdyN(trdyN), .doneValid(doneValid)
);

// File: tb/mux_bus_initiator_test.sv
module mux_bus_initiator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [31:0] cmdAddr = '0, cmdWdata = '0, adIn = '0;
  logic        gntN = 1'b1, busFrameN = 1'b1, trdyN = 1'b1;
  logic        cmdReady, doneValid, reqN, frameN, adOe;
  logic [31:0] doneRdata, adOut;
  logic [3:0]  cmdType;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mux_bus_initiator uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdReady(cmdReady),
    .doneValid(doneValid), .doneRdata(doneRdata), .reqN(reqN), .gntN(gntN),
    .busFrameN(busFrameN), .frameN(frameN), .cmdType(cmdType), .adOut(adOut),
    .adOe(adOe), .adIn(adIn), .trdyN(trdyN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Full transaction; the bench acts as client, arbiter and target.
  task automatic runTxn(input bit wr, input logic [31:0] addr, input logic [31:0] wdat,
                        input logic [31:0] rdat, input int gntDelay, input int busyDelay,
                        input int waits, input bit pokeBusy);
    cmdValid = 1'b1; cmdWrite = wr; cmdAddr = addr; cmdWdata = wdat;
    step();
    cmdValid = 1'b0;
    check(reqN == 1'b0 && frameN == 1'b1, "R2 request after accept", {30'd0, reqN, frameN}, 32'd1);
    check(cmdReady == 1'b0, "R10 busy after accept", {31'd0, cmdReady}, 32'd0);
    for (int i = 0; i < gntDelay; i++) begin
      step();
      check(frameN == 1'b1 && reqN == 1'b0, "R3 no frame without grant", {30'd0, reqN, frameN}, 32'd1);
    end
    gntN = 1'b0;
    busFrameN = (busyDelay == 0);
    for (int i = 0; i < busyDelay; i++) begin
      step();
      check(frameN == 1'b1, "R3 no frame while bus busy", {31'd0, frameN}, 32'd1);
      if (i == busyDelay - 1) busFrameN = 1'b1;
    end
    step();
    gntN = 1'b1;
    check(frameN == 1'b0 && adOe == 1'b1, "R4 address phase strobes", {30'd0, frameN, adOe}, 32'd1);
    check(adOut == addr, "R4 address on bus", adOut, addr);
    check(cmdType == (wr ? 4'b0111 : 4'b0110), "R4 command code", {28'd0, cmdType}, wr ? 32'd7 : 32'd6);
    check(reqN == 1'b1, "R9 request dropped", {31'd0, reqN}, 32'd1);
    if (pokeBusy) begin cmdValid = 1'b1; cmdAddr = 32'hDEAD0000; end
    step();
    if (!wr) begin
      check(adOe == 1'b0 && frameN == 1'b0, "R5 turnaround", {30'd0, adOe, frameN}, 32'd0);
      step();
      check(adOe == 1'b0, "R5 read data phase released", {31'd0, adOe}, 32'd0);
    end else begin
      check(adOe == 1'b1 && frameN == 1'b0, "R6 write data phase strobes", {30'd0, adOe, frameN}, 32'd2);
      check(adOut == wdat && cmdType == 4'b0000, "R6 write data and enables", adOut, wdat);
    end
    cmdValid = 1'b0;
    for (int i = 0; i < waits; i++) begin
      step();
      check(frameN == 1'b0 && adOe == wr && cmdType == 4'b0000, "R7 wait state held", {30'd0, frameN, adOe}, {31'd0, wr});
      if (wr) check(adOut == wdat, "R7 write data held", adOut, wdat);
    end
    trdyN = 1'b0; adIn = rdat;
    step();
    trdyN = 1'b1; adIn = 32'h0;
    check(doneValid == 1'b1 && frameN == 1'b1 && adOe == 1'b0, "R8 idle cycle with done",
          {29'd0, doneValid, frameN, adOe}, 32'd6);
    if (!wr) check(doneRdata == rdat, "R8 read data returned", doneRdata, rdat);
    step();
    check(doneValid == 1'b0 && cmdReady == 1'b1, "R8 done single cycle", {30'd0, doneValid, cmdReady}, 32'd1);
  endtask

  task automatic testReset();
    check(reqN && frameN && !adOe && !doneValid && cmdReady, "R1 reset state",
          {27'd0, reqN, frameN, adOe, doneValid, cmdReady}, 32'b11001);
  endtask

  task automatic testReadFast();
    runTxn(1'b0, 32'h1000_0040, 32'h0, 32'hCAFE_F00D, 0, 0, 0, 1'b0);
  endtask

  task automatic testWriteWaits();
    runTxn(1'b1, 32'h2000_0010, 32'h1234_5678, 32'h0, 2, 0, 3, 1'b0);
  endtask

  task automatic testReadBusyBus();
    runTxn(1'b0, 32'h3000_0004, 32'h0, 32'hA5A5_5A5A, 1, 2, 2, 1'b0);
  endtask

  task automatic testIgnoreWhileBusy();
    runTxn(1'b1, 32'h4000_0000, 32'hFFFF_0001, 32'h0, 0, 0, 1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step();
      check(reqN == 1'b1 && frameN == 1'b1, "R10 ignored command not run", {30'd0, reqN, frameN}, 32'd3);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    testReset();
    step();
    rstN = 1'b1;
    step();
    testReset();
    testReadFast();
    testWriteWaits();
    testReadBusyBus();
    testIgnoreWhileBusy();
    testReadFast();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule